// File: doc/BRIEF.md
# Masked Register Field Update Engine

This block turns one host command word into a complete field update on a register that sits behind a slow peripheral access port. The host writes a 32-bit command that names an operation, a peripheral register, a field mask and a field value. The engine reads that register and changes only the bits the mask selects. It writes the merged byte back and then reads a fixed sample register of the peripheral. The sample lands in a result register that the host can read directly, with no shifting or masking left to do in software.

The field value is given right-justified. The engine moves it into place by shifting it left by the position of the lowest set bit of the mask. On the peripheral side, each access is a request that is held steady until a one-cycle done pulse arrives. Any serial wire protocol lives beyond that port. A busy flag covers the whole sequence. Two error flags report a command that arrived while the engine was busy and a command with an opcode the engine does not know.

Top module: `fieldrmw_engine`

## Requirements
- R1: The command word holds, from most to least significant byte, the opcode [31:24], the register address [23:16], the field mask [15:8] and the right-justified field value [7:0]. Opcode 0x22 starts an update sequence.
- R2: An accepted update issues peripheral accesses in a fixed order: a read of the addressed register, then a write to the same address, then a read of the sample address SAMPLE_ADDR (default 0xF0).
- R3: The written byte equals (old & ~mask) | ((value << s) & mask), where s is the index of the lowest set bit of the mask. Bits outside the mask keep their old value.
- R4: Value bits that land outside the mask after the shift are dropped and do not reach the register.
- R5: With a zero mask, the write access is skipped. The register read and the sample read still take place, and the register is left unchanged.
- R6: rd_result takes the sample byte when the sample access completes. At every other time it holds its value. It is zero after reset.
- R7: busy rises in the cycle after an accepted command and falls in the cycle after the sample access completes.
- R8: A command write while busy is ignored and sets err_busy. Both error flags clear when the next command is accepted while the engine is idle.
- R9: An opcode other than 0x22 makes no peripheral access, leaves busy low and sets err_badop.
- R10: pr_req stays high with stable pr_we, pr_addr and pr_wdata until pr_done. pr_done ends exactly one access.
- R11: After reset, busy, both error flags, pr_req and rd_result are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | One-cycle command write strobe |
| host_cmd | input | 32 | Command word: opcode, address, mask, value |
| busy | output | 1 | Update sequence in progress |
| err_busy | output | 1 | A command arrived while busy |
| err_badop | output | 1 | Last accepted command had an unknown opcode |
| rd_result | output | 8 | Sample byte from the last completed sequence |
| pr_req | output | 1 | Peripheral access request |
| pr_we | output | 1 | Access is a write |
| pr_addr | output | 8 | Peripheral register address |
| pr_wdata | output | 8 | Write data |
| pr_rdata | input | 8 | Read data, valid with pr_done |
| pr_done | input | 1 | Access complete, one-cycle pulse |

## Verification
The merge is tried with several masks, each of which separates a different fault:
- A middle field (bits 5..3) checks both the shift and the preservation of the bits around it.
- A narrow field with an oversized value checks that overflow bits are dropped.
- A top-bit-only mask checks the largest shift.
- A full mask checks that the whole byte is replaced.
- A zero mask must produce two accesses instead of three and leave the register unchanged. This separates write suppression from a write of the old value.

Unknown opcodes, collisions while busy and the clearing of the error flags are checked at the ports by counting peripheral accesses and reading the target registers back.

// File: rtl/fieldrmw_pkg.sv
package fieldrmw_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_FETCH  = 2'd1,
        PH_STORE  = 2'd2,
        PH_SAMPLE = 2'd3
    } rmw_phase_e;

endpackage

// File: rtl/fieldrmw_decode.sv
module fieldrmw_decode #(
    parameter int          OPW    = 8,
    parameter int          AW     = 8,
    parameter int          DW     = 8,
    parameter logic [7:0]  RMW_OP = 8'h22,
    localparam int         CW     = OPW + AW + 2 * DW,
    localparam int         SW     = (DW > 1) ? $clog2(DW) : 1
) (
    input  logic [CW-1:0] cmd,
    output logic          op_ok,
    output logic [AW-1:0] f_addr,
    output logic [DW-1:0] f_mask,
    output logic [DW-1:0] f_aligned
);

    logic [OPW-1:0] opcode;
    logic [DW-1:0]  raw_val;
    logic [SW-1:0]  lsb_idx;
    logic           lsb_found;

    assign opcode  = cmd[CW-1 -: OPW];
    assign f_addr  = cmd[2*DW +: AW];
    assign f_mask  = cmd[DW +: DW];
    assign raw_val = cmd[0 +: DW];
    assign op_ok   = (opcode == OPW'(RMW_OP));

    // find the lowest set bit of the mask; a zero mask gives shift 0
    always_comb begin
        lsb_idx   = '0;
        lsb_found = 1'b0;
        for (int i = 0; i < DW; i++) begin
            if (f_mask[i] && !lsb_found) begin
                lsb_idx   = SW'(i);
                lsb_found = 1'b1;
            end
        end
    end

    // shifted value, bits that fall outside the field are dropped
    assign f_aligned = (raw_val << lsb_idx) & f_mask;

endmodule

// File: rtl/fieldrmw_merge.sv
module fieldrmw_merge #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] old_val,
    input  logic [DW-1:0] mask,
    input  logic [DW-1:0] aligned,
    output logic [DW-1:0] merged
);

    assign merged = (old_val & ~mask) | (aligned & mask);

endmodule

// File: rtl/fieldrmw_seq.sv
module fieldrmw_seq
    import fieldrmw_pkg::*;
#(
    parameter int         AW          = 8,
    parameter int         DW          = 8,
    parameter logic [7:0] SAMPLE_ADDR = 8'hF0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_wr,
    input  logic          op_ok,
    input  logic [AW-1:0] f_addr,
    input  logic [DW-1:0] f_mask,
    input  logic [DW-1:0] f_aligned,
    output logic          busy,
    output logic          err_busy,
    output logic          err_badop,
    output logic [DW-1:0] rd_result,
    output logic          pr_req,
    output logic          pr_we,
    output logic [AW-1:0] pr_addr,
    output logic [DW-1:0] pr_wdata,
    input  logic [DW-1:0] pr_rdata,
    input  logic          pr_done
);

    typedef struct packed {
        rmw_phase_e    phase;
        logic [AW-1:0] addr;
        logic [DW-1:0] mask;
        logic [DW-1:0] aligned;
        logic [DW-1:0] old_val;
        logic [DW-1:0] result;
        logic          err_busy;
        logic          err_badop;
    } seq_regs_t;

    seq_regs_t     r_q, r_d;
    logic [DW-1:0] merged;

    fieldrmw_merge #(.DW(DW)) u_merge (
        .old_val (r_q.old_val),
        .mask    (r_q.mask),
        .aligned (r_q.aligned),
        .merged  (merged)
    );

    always_comb begin
        r_d = r_q;
        if (r_q.phase != PH_IDLE && host_wr)
            r_d.err_busy = 1'b1;
        unique case (r_q.phase)
            PH_IDLE: begin
                if (host_wr) begin
                    r_d.err_busy  = 1'b0;
                    r_d.err_badop = !op_ok;
                    if (op_ok) begin
                        r_d.addr    = f_addr;
                        r_d.mask    = f_mask;
                        r_d.aligned = f_aligned;
                        r_d.phase   = PH_FETCH;
                    end
                end
            end
            PH_FETCH: begin
                if (pr_done) begin
                    r_d.old_val = pr_rdata;
                    r_d.phase   = (r_q.mask == '0) ? PH_SAMPLE : PH_STORE;
                end
            end
            PH_STORE: begin
                if (pr_done)
                    r_d.phase = PH_SAMPLE;
            end
            PH_SAMPLE: begin
                if (pr_done) begin
                    r_d.result = pr_rdata;
                    r_d.phase  = PH_IDLE;
                end
            end
            default: r_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{phase: PH_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign busy      = (r_q.phase != PH_IDLE);
    assign err_busy  = r_q.err_busy;
    assign err_badop = r_q.err_badop;
    assign rd_result = r_q.result;
    assign pr_req    = (r_q.phase != PH_IDLE);
    assign pr_we     = (r_q.phase == PH_STORE);
    assign pr_addr   = (r_q.phase == PH_SAMPLE) ? AW'(SAMPLE_ADDR) : r_q.addr;
    assign pr_wdata  = (r_q.phase == PH_STORE) ? merged : '0;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        pr_req && !pr_done |=> pr_req && $stable(pr_we) && $stable(pr_addr) && $stable(pr_wdata)); // R10
    AST_OUTSIDE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        pr_req && pr_we |-> ((pr_wdata ^ r_q.old_val) & ~r_q.mask) == '0); // R3
    AST_NO_EMPTY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        pr_req && pr_we |-> r_q.mask != '0); // R5
    AST_COLLIDE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        busy && host_wr |=> err_busy); // R8
    AST_BADOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && host_wr && !op_ok |=> !pr_req && err_badop); // R9
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !(r_q.phase == PH_SAMPLE && pr_done) |=> $stable(rd_result)); // R6
    AST_WRITE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pr_we) |-> $past(pr_req) && !$past(pr_we) && $past(pr_done)); // R2

endmodule

// File: rtl/fieldrmw_engine.sv
module fieldrmw_engine #(
    parameter int         OPW         = 8,
    parameter int         AW          = 8,
    parameter int         DW          = 8,
    parameter logic [7:0] RMW_OP      = 8'h22,
    parameter logic [7:0] SAMPLE_ADDR = 8'hF0,
    localparam int        CW          = OPW + AW + 2 * DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_wr,
    input  logic [CW-1:0] host_cmd,
    output logic          busy,
    output logic          err_busy,
    output logic          err_badop,
    output logic [DW-1:0] rd_result,
    output logic          pr_req,
    output logic          pr_we,
    output logic [AW-1:0] pr_addr,
    output logic [DW-1:0] pr_wdata,
    input  logic [DW-1:0] pr_rdata,
    input  logic          pr_done
);

    logic          op_ok;
    logic [AW-1:0] f_addr;
    logic [DW-1:0] f_mask;
    logic [DW-1:0] f_aligned;

    fieldrmw_decode #(
        .OPW(OPW), .AW(AW), .DW(DW), .RMW_OP(RMW_OP)
    ) u_decode (
        .cmd       (host_cmd),
        .op_ok     (op_ok),
        .f_addr    (f_addr),
        .f_mask    (f_mask),
        .f_aligned (f_aligned)
    );

    fieldrmw_seq #(
        .AW(AW), .DW(DW), .SAMPLE_ADDR(SAMPLE_ADDR)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .host_wr   (host_wr),
        .op_ok     (op_ok),
        .f_addr    (f_addr),
        .f_mask    (f_mask),
        .f_aligned (f_aligned),
        .busy      (busy),
        .err_busy  (err_busy),
        .err_badop (err_badop),
        .rd_result (rd_result),
        .pr_req    (pr_req),
        .pr_we     (pr_we),
        .pr_addr   (pr_addr),
        .pr_wdata  (pr_wdata),
        .pr_rdata  (pr_rdata),
        .pr_done   (pr_done)
    );

endmodule

// File: tb/fieldrmw_engine_test.sv
module fieldrmw_engine_test;

    localparam int         LAT  = 2;
    localparam logic [7:0] SMPA = 8'hF0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic [31:0] host_cmd = '0;
    logic        busy, err_busy, err_badop;
    logic [7:0]  rd_result;
    logic        pr_req, pr_we;
    logic [7:0]  pr_addr, pr_wdata;
    logic [7:0]  pr_rdata;
    logic        pr_done;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    fieldrmw_engine uut (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_cmd(host_cmd),
        .busy(busy), .err_busy(err_busy), .err_badop(err_badop), .rd_result(rd_result),
        .pr_req(pr_req), .pr_we(pr_we), .pr_addr(pr_addr), .pr_wdata(pr_wdata),
        .pr_rdata(pr_rdata), .pr_done(pr_done)
    );

    // peripheral model: register file with fixed latency and an access log
    logic [7:0] mem [0:255];
    logic       pre_we = 1'b0;
    logic [7:0] pre_addr = '0, pre_data = '0;
    int         cnt = 0;
    int         ntx = 0;
    int         nwr = 0;
    logic [7:0] log_addr [0:63];
    logic       log_we   [0:63];

    always_ff @(posedge clk) begin
        pr_done <= 1'b0;
        if (pre_we) mem[pre_addr] <= pre_data;
        if (pr_req && !pr_done) begin
            if (cnt == LAT) begin
                cnt <= 0;
                pr_done <= 1'b1;
                pr_rdata <= mem[pr_addr];
                if (pr_we) begin
                    mem[pr_addr] <= pr_wdata;
                    nwr <= nwr + 1;
                end
                log_addr[ntx % 64] <= pr_addr;
                log_we[ntx % 64]   <= pr_we;
                ntx <= ntx + 1;
            end else begin
                cnt <= cnt + 1;
            end
        end
    end

    initial begin
        pr_done = 1'b0;
        pr_rdata = '0;
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic preload(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        pre_we = 1'b1; pre_addr = a; pre_data = d;
        @(negedge clk);
        pre_we = 1'b0;
    endtask

    task automatic issue(input logic [31:0] c);
        @(negedge clk);
        host_cmd = c; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic wait_idle();
        int g = 0;
        while (busy && g < 1000) begin
            @(negedge clk);
            g++;
        end
    endtask

    // R1 R2 R3 R6 R7: standard update, middle field
    task automatic t_basic();
        int base;
        preload(8'h14, 8'hC7);
        preload(SMPA, 8'h5A);
        base = ntx;
        issue(32'h2214_3802);
        check(busy === 1'b1, "R7 busy after accept", busy, 1);
        wait_idle();
        check(ntx - base == 3, "R2 access count", ntx - base, 3);
        check(log_addr[base % 64] == 8'h14 && !log_we[base % 64], "R2 first is read of target",
              log_addr[base % 64], 8'h14);
        check(log_addr[(base + 1) % 64] == 8'h14 && log_we[(base + 1) % 64], "R2 second is write of target",
              log_addr[(base + 1) % 64], 8'h14);
        check(log_addr[(base + 2) % 64] == SMPA && !log_we[(base + 2) % 64], "R2 third is sample read",
              log_addr[(base + 2) % 64], SMPA);
        check(mem[8'h14] == 8'hD7, "R3 R1 merged field bits 5..3", mem[8'h14], 8'hD7);
        check(rd_result == 8'h5A, "R6 sample result", rd_result, 8'h5A);
        check(busy === 1'b0, "R7 busy clear at end", busy, 0);
    endtask

    // R4: oversized value in narrow field
    task automatic t_overflow();
        preload(8'h20, 8'h00);
        issue(32'h2220_0C07);
        wait_idle();
        check(mem[8'h20] == 8'h0C, "R4 overflow dropped", mem[8'h20], 8'h0C);
    endtask

    // R3: top bit only, largest shift
    task automatic t_top_bit();
        preload(8'h21, 8'h01);
        issue(32'h2221_8001);
        wait_idle();
        check(mem[8'h21] == 8'h81, "R3 top bit shift", mem[8'h21], 8'h81);
    endtask

    // R3: full mask replaces the whole byte
    task automatic t_full();
        preload(8'h22, 8'h3C);
        issue(32'h2222_FFA5);
        wait_idle();
        check(mem[8'h22] == 8'hA5, "R3 full mask", mem[8'h22], 8'hA5);
    endtask

    // R5 R6: zero mask skips the write
    task automatic t_zero_mask();
        int base, wbase;
        preload(8'h23, 8'h77);
        preload(SMPA, 8'h99);
        base = ntx; wbase = nwr;
        issue(32'h2223_00FF);
        wait_idle();
        check(ntx - base == 2, "R5 two accesses", ntx - base, 2);
        check(nwr == wbase, "R5 no write", nwr - wbase, 0);
        check(mem[8'h23] == 8'h77, "R5 register unchanged", mem[8'h23], 8'h77);
        check(rd_result == 8'h99, "R5 R6 sample still taken", rd_result, 8'h99);
    endtask

    // R9: unknown opcode
    task automatic t_badop();
        int base;
        logic [7:0] keep;
        keep = rd_result;
        base = ntx;
        preload(8'h24, 8'h11);
        issue(32'h5524_FF00);
        check(busy === 1'b0, "R9 busy stays low", busy, 0);
        check(err_badop === 1'b1, "R9 error set", err_badop, 1);
        repeat (8) @(negedge clk);
        check(ntx == base, "R9 no access", ntx - base, 0);
        check(mem[8'h24] == 8'h11 && rd_result == keep, "R9 nothing touched", mem[8'h24], 8'h11);
    endtask

    // R8: command while busy is ignored
    task automatic t_collide();
        int base;
        preload(8'h25, 8'h00);
        preload(8'h30, 8'h44);
        base = ntx;
        issue(32'h2225_0F03);
        issue(32'h2230_FF11);
        wait_idle();
        check(err_busy === 1'b1, "R8 collision flagged", err_busy, 1);
        check(mem[8'h30] == 8'h44, "R8 second command ignored", mem[8'h30], 8'h44);
        check(mem[8'h25] == 8'h03, "R8 first command completes", mem[8'h25], 8'h03);
        check(ntx - base == 3, "R8 only one sequence", ntx - base, 3);
    endtask

    // R8: flags clear on next accepted command
    task automatic t_err_clear();
        issue(32'h2226_0101);
        check(err_busy === 1'b0 && err_badop === 1'b0, "R8 flags cleared", {err_busy, err_badop}, 0);
        wait_idle();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        check(busy === 1'b0 && err_busy === 1'b0 && err_badop === 1'b0, "R11 flags in reset",
              {busy, err_busy, err_badop}, 0);
        check(pr_req === 1'b0 && rd_result === 8'h00, "R11 port idle in reset", rd_result, 0);
        rst_n = 1'b1;
        t_basic();
        t_overflow();
        t_top_bit();
        t_full();
        t_zero_mask();
        t_badop();
        t_collide();
        t_err_clear();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule